// File: doc/BRIEF.md
# PCI I/O Target for a Parallel-Port Register Window

This block sits on a 32-bit PCI bus as a target that answers only I/O read and I/O write transactions. In the address phase it decodes the address and command with no pipeline stage. If the address falls in one of its two windows, it claims the cycle by pulling DEVSEL low on the following clock. It then runs data phases until the initiator signals the last one, and inserts wait states whenever either side is not ready.

The initiator gives only the start address. The block keeps its own dword counter and steps it once per completed data phase. Each completed phase becomes a single-cycle strobe on a simple internal register port. The port carries a window select, a dword index, byte enables and write data, and returns read data combinationally. The primary window is 8 bytes (two dwords) holding the standard printer registers. The secondary window is one dword holding the two configuration registers and the extended control register.

AD is split into an input bus, an output bus and an output enable, so that the bidirectional pad sits outside the block.

Top module: `pci_io_target`

## Requirements
- R1: While rst_n is low, and on the first clock after it, devsel_n and trdy_n are high, ad_oe is low, and reg_we and reg_re are low.
- R2: A transaction is claimed (devsel_n low on the clock after the address phase) only when C/BE carries 0010 (I/O read) or 0011 (I/O write) and the address lies in the primary window (8 bytes at STD_BASE) or the secondary window (4 bytes at CFG_BASE). For any other command or address, devsel_n stays high and no strobe occurs until the bus returns to idle.
- R3: The primary window maps to reg_win=0, with reg_idx equal to address bit 2. The secondary window maps to reg_win=1, holding bytes 0, 1 and 2 of one dword. reg_sel is high while the current address is inside a window.
- R4: On a write, trdy_n goes low together with devsel_n. Each completed phase gives a one-cycle reg_we, with reg_wdata equal to ad_in and reg_be[i] equal to the inverse of cbe_n[i], so that bit i enables byte lane i.
- R5: A data phase completes only on a clock where both irdy_n and trdy_n are low. In a wait state, reg_we and reg_re stay low.
- R6: Each completed data phase advances the internal address by 4 bytes. A phase whose address has left both windows still completes, but it writes nothing, and a read returns zero.
- R7: When a phase completes with frame_n high, devsel_n and trdy_n are high and ad_oe is low on the next clock.
- R8: On a read, the first cycle with devsel_n low has ad_oe low and trdy_n high, as a turnaround. From the next clock, ad_oe is high, trdy_n is low, and ad_out carries reg_rdata.
- R9: A write phase with cbe_n = 1111 completes without a reg_we strobe, and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| ad_in | input | 32 | AD bus as seen from the pads |
| ad_out | output | 32 | Read data toward the AD pads |
| ad_oe | output | 1 | Drive enable for ad_out |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables afterwards |
| frame_n | input | 1 | Initiator frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | output | 1 | Target ready, active low |
| devsel_n | output | 1 | Device select, active low |
| reg_sel | output | 1 | Current address is inside a window |
| reg_win | output | 1 | 0 primary window, 1 secondary window |
| reg_idx | output | 1 | Dword index inside the primary window |
| reg_we | output | 1 | Write strobe, one cycle per completed write phase |
| reg_re | output | 1 | Read strobe, one cycle per completed read phase |
| reg_be | output | 4 | Active-high byte enables |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data for the addressed dword |

## Verification
On every clock, the bound checker confirms four things:
- every fall of devsel_n follows an address phase with an I/O command;
- a register strobe appears only with both ready signals low;
- the target releases on the clock after the last transfer;
- a read never drives AD in its first claimed cycle, and the counter steps by one dword per non-final phase.

Only the bench's scenarios can show the rest. That covers correct claiming against the two windows, the data returned after byte-lane writes, and the dropping of writes and zeroing of reads once a burst walks off a window. It also covers the lack of effect of an all-disabled write, and recovery from a reset in the middle of a transaction.

// File: rtl/pci_io_target.sv
module pci_io_target #(
  parameter logic [31:0] STD_BASE = 32'h0000_0378,
  parameter logic [31:0] CFG_BASE = 32'h0000_0778
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  input  logic [3:0]  cbe_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  output logic        trdy_n,
  output logic        devsel_n,
  output logic        reg_sel,
  output logic        reg_win,
  output logic        reg_idx,
  output logic        reg_we,
  output logic        reg_re,
  output logic [3:0]  reg_be,
  output logic [31:0] reg_wdata,
  input  logic [31:0] reg_rdata
);
  localparam logic [2:0] IO_CMD_HI = 3'b001;

  typedef enum logic [1:0] {S_IDLE, S_SKIP, S_TURN, S_DATA} st_t;

  st_t         st;
  logic        frame_q;
  logic        wr;
  logic [29:0] cur;

  wire addr_ph = (st == S_IDLE) && !frame_n && frame_q;
  wire io_cmd  = (cbe_n[3:1] == IO_CMD_HI);
  wire new_hit = (ad_in[31:3] == STD_BASE[31:3]) || (ad_in[31:2] == CFG_BASE[31:2]);
  wire xfer    = (st == S_DATA) && !irdy_n && !trdy_n;
  wire std_hit = (cur[29:1] == STD_BASE[31:3]);
  wire cfg_hit = (cur == CFG_BASE[31:2]);

  assign reg_sel   = std_hit || cfg_hit;
  assign reg_win   = cfg_hit;
  assign reg_idx   = cur[0];
  assign reg_be    = ~cbe_n;
  assign reg_wdata = ad_in;
  assign reg_we    = xfer && wr && reg_sel && (cbe_n != 4'hF);
  assign reg_re    = xfer && !wr && reg_sel;
  assign ad_out    = (ad_oe && reg_sel) ? reg_rdata : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      frame_q  <= 1'b1;
      wr       <= 1'b0;
      cur      <= '0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      ad_oe    <= 1'b0;
    end else begin
      frame_q <= frame_n;
      case (st)
        S_IDLE: if (addr_ph) begin
          if (io_cmd && new_hit) begin
            cur      <= ad_in[31:2];
            wr       <= cbe_n[0];
            devsel_n <= 1'b0;
            trdy_n   <= !cbe_n[0];
            st       <= cbe_n[0] ? S_DATA : S_TURN;
          end else begin
            st <= S_SKIP;
          end
        end
        S_SKIP: if (frame_n && irdy_n) st <= S_IDLE;
        S_TURN: begin
          trdy_n <= 1'b0;
          ad_oe  <= 1'b1;
          st     <= S_DATA;
        end
        default: if (xfer) begin
          cur <= cur + 30'd1;
          if (frame_n) begin
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            ad_oe    <= 1'b0;
            st       <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pci_io_target_chk.sv
module pci_io_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cbe_n,
  input logic        frame_n,
  input logic        irdy_n,
  input logic        trdy_n,
  input logic        devsel_n,
  input logic        ad_oe,
  input logic        reg_we,
  input logic        reg_re,
  input logic [29:0] cur
);
  a_r2_claim_io_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(!frame_n && cbe_n[3:1] == 3'b001));

  a_r5_strobe_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || reg_re) |-> (!irdy_n && !trdy_n && !devsel_n));

  a_r7_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && !irdy_n && !trdy_n && frame_n) |=> (devsel_n && trdy_n && !ad_oe));

  a_r8_read_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(devsel_n) && trdy_n) |-> !ad_oe);

  a_r6_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && !irdy_n && !trdy_n && !frame_n) |=> (cur == $past(cur) + 30'd1));

  a_r1_trdy_needs_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);
endmodule

bind pci_io_target pci_io_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .trdy_n(trdy_n), .devsel_n(devsel_n), .ad_oe(ad_oe), .reg_we(reg_we),
  .reg_re(reg_re), .cur(cur)
);

// File: tb/tb_pci_io_target.sv
module tb_pci_io_target;
  localparam logic [3:0] RD = 4'b0010, WR = 4'b0011;
  localparam int NV = 14;
  // {cmd, addr, wdata, cbe_n, claim, expected read}
  localparam logic [104:0] VEC [NV] = '{
    {WR, 32'h378, 32'h44332211, 4'h0, 1'b1, 32'h0},
    {WR, 32'h37C, 32'h88776655, 4'h0, 1'b1, 32'h0},
    {WR, 32'h778, 32'hDDCCBBAA, 4'h0, 1'b1, 32'h0},
    {RD, 32'h378, 32'h0,        4'h0, 1'b1, 32'h44332211},
    {RD, 32'h37C, 32'h0,        4'h0, 1'b1, 32'h88776655},
    {RD, 32'h778, 32'h0,        4'h0, 1'b1, 32'h00CCBBAA},
    {WR, 32'h378, 32'hFFFFFF99, 4'hE, 1'b1, 32'h0},
    {RD, 32'h378, 32'h0,        4'h0, 1'b1, 32'h44332299},
    {4'b1010, 32'h378, 32'h0,   4'h0, 1'b0, 32'h0},
    {4'b0111, 32'h378, 32'h0,   4'h0, 1'b0, 32'h0},
    {RD, 32'h380, 32'h0,        4'h0, 1'b0, 32'h0},
    {RD, 32'h378, 32'h0,        4'h0, 1'b1, 32'h44332299},
    {WR, 32'h37C, 32'h0,        4'hF, 1'b1, 32'h0},
    {RD, 32'h37C, 32'h0,        4'h0, 1'b1, 32'h88776655}
  };

  logic clk = 0, rst_n = 0;
  logic [31:0] ad_in = 0, ad_out, reg_wdata, reg_rdata;
  logic [3:0] cbe_n = 4'hF, reg_be;
  logic frame_n = 1, irdy_n = 1;
  logic ad_oe, trdy_n, devsel_n, reg_sel, reg_win, reg_idx, reg_we, reg_re;
  int checks = 0, fails = 0, we_cnt = 0;
  bit done = 0;
  logic [7:0] std_mem [8];
  logic [7:0] cfg_mem [3];
  logic [31:0] wbuf [4], ebuf [4];

  always #4 clk = ~clk;

  pci_io_target dut (.*);

  always_comb begin
    if (reg_win) reg_rdata = {8'h00, cfg_mem[2], cfg_mem[1], cfg_mem[0]};
    else reg_rdata = {std_mem[{reg_idx, 2'd3}], std_mem[{reg_idx, 2'd2}],
                      std_mem[{reg_idx, 2'd1}], std_mem[{reg_idx, 2'd0}]};
  end

  always @(posedge clk) if (reg_we) begin
    we_cnt <= we_cnt + 1;
    for (int b = 0; b < 4; b++)
      if (reg_be[b]) begin
        if (!reg_win) std_mem[{reg_idx, b[1:0]}] <= reg_wdata[8*b +: 8];
        else if (b < 3) cfg_mem[b] <= reg_wdata[8*b +: 8];
      end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(devsel_n && trdy_n && !ad_oe && !reg_we && !reg_re, req,
        {27'd0, devsel_n, trdy_n, ad_oe, reg_we, reg_re}, 32'h18);
  endtask

  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                     input int waits, input logic [3:0] be, input bit claim);
    int k = 0, w = waits, guard = 0;
    bit rd = (cmd == RD);
    @(negedge clk);
    frame_n = 0; irdy_n = 1; ad_in = addr; cbe_n = cmd;
    @(negedge clk);
    cbe_n = be; ad_in = wbuf[0];
    if (!claim) begin
      irdy_n = 0; frame_n = 1;
      for (int c = 0; c < 3; c++) begin
        #1 chk(devsel_n && trdy_n && !reg_we && !reg_re, "R2 unclaimed",
               {30'd0, devsel_n, trdy_n}, 32'h3);
        @(negedge clk);
      end
      irdy_n = 1;
      @(negedge clk);
      return;
    end
    chk(!devsel_n, "R2 claim", {31'd0, devsel_n}, 32'h0);
    if (rd) chk(trdy_n && !ad_oe, "R8 turnaround", {30'd0, trdy_n, ad_oe}, 32'h2);
    else    chk(!trdy_n, "R4 write trdy with devsel", {31'd0, trdy_n}, 32'h0);
    if (w > 0) begin irdy_n = 1; w--; end
    else begin irdy_n = 0; frame_n = (n == 1); end
    forever begin
      #1;
      if (!irdy_n && !trdy_n) begin
        if (rd) chk(ad_oe && ad_out == ebuf[k], "R8/R6 read data", ad_out, ebuf[k]);
        k++;
      end else begin
        chk(!reg_we && !reg_re, "R5 no strobe in wait", {30'd0, reg_we, reg_re}, 32'h0);
      end
      @(negedge clk);
      guard++;
      if (k == n || guard > 60) begin
        frame_n = 1; irdy_n = 1;
        check_idle("R7 release after last");
        break;
      end
      ad_in = wbuf[k];
      if (w > 0) begin irdy_n = 1; w--; end
      else begin irdy_n = 0; frame_n = (k == n - 1); w = waits; end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    for (int i = 0; i < 8; i++) std_mem[i] = 8'h0;
    for (int i = 0; i < 3; i++) cfg_mem[i] = 8'h0;
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    rst_n = 1;
    @(negedge clk);
    check_idle("R1 after reset");

    for (int v = 0; v < NV; v++) begin
      base = we_cnt;
      wbuf[0] = VEC[v][68:37];
      ebuf[0] = VEC[v][31:0];
      txn(VEC[v][104:101], VEC[v][100:69], 1, v % 3, VEC[v][36:33], VEC[v][32]);
      if (VEC[v][104:101] == WR && VEC[v][32])
        chk((we_cnt - base) == (VEC[v][36:33] == 4'hF ? 0 : 1), "R4/R9 write strobes",
            we_cnt - base, VEC[v][36:33] == 4'hF ? 0 : 1);
    end

    // R6: burst off the end of the primary window
    base = we_cnt;
    wbuf[0] = 32'hA0A1A2A3; wbuf[1] = 32'hB0B1B2B3; wbuf[2] = 32'hC0C1C2C3;
    txn(WR, 32'h378, 3, 2, 4'h0, 1'b1);
    chk((we_cnt - base) == 2, "R6 out-of-window write dropped", we_cnt - base, 2);
    ebuf[0] = 32'hA0A1A2A3; ebuf[1] = 32'hB0B1B2B3; ebuf[2] = 32'h0;
    txn(RD, 32'h378, 3, 1, 4'h0, 1'b1);
    // R3/R6: secondary window burst, second dword outside
    ebuf[0] = 32'h00CCBBAA; ebuf[1] = 32'h0;
    txn(RD, 32'h778, 2, 0, 4'h0, 1'b1);
    // R3: single-lane write to secondary window byte 1
    wbuf[0] = 32'h00005500;
    txn(WR, 32'h778, 1, 0, 4'hD, 1'b1);
    ebuf[0] = 32'h00CC55AA;
    txn(RD, 32'h778, 1, 0, 4'h0, 1'b1);

    // R1: reset in the middle of a claimed write
    @(negedge clk);
    frame_n = 0; ad_in = 32'h378; cbe_n = WR;
    @(negedge clk);
    cbe_n = 4'h0; irdy_n = 1;
    chk(!devsel_n, "R2 claim before reset", {31'd0, devsel_n}, 0);
    rst_n = 0;
    #1 check_idle("R1 reset mid-transaction");
    @(negedge clk);
    frame_n = 1; irdy_n = 1;
    rst_n = 1;
    @(negedge clk);
    check_idle("R1 idle after reset");
    ebuf[0] = 32'hA0A1A2A3;
    txn(RD, 32'h378, 1, 0, 4'h0, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule